// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block holds the register file of one UART channel and decodes accesses to it from an 8-bit parallel host bus. The bus has a 3-bit address, one-cycle read and write strobes, write data in, and read data out. Only eight addresses are visible, but the channel has seventeen registers. Three register banks share the address space, and the value last written to the line control register picks which bank the host sees. The general bank is visible while bit 7 of that register is clear. The divisor bank is visible while bit 7 is set. The enhanced bank, which holds the feature register and the four flow-control characters, is visible only while the register holds exactly 0xBF.

Several parts of the channel sit outside this block: the serial shifter, the baud generator, the FIFOs and the interrupt logic. They reach the block through plain side ports. Receive data, the interrupt status, the line status and the modem status come in as read-only values, and every stored register is driven out as a level. A read of receive data produces a one-cycle pop pulse toward the receive FIFO. A write of transmit data produces a one-cycle push pulse toward the transmit FIFO, and the written byte is held on its own output.

The bank is tracked by a three-state machine with the states BANK_GEN, BANK_DIV and BANK_ENH. Any write to the line control register moves the machine. A written value of 0xBF moves it to BANK_ENH. Any other value with bit 7 set moves it to BANK_DIV. A value with bit 7 clear moves it to BANK_GEN. Every state can reach every other state in one write, and a write of the same class keeps the current state.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset, the line control, interrupt enable, FIFO control, modem control, scratchpad, divisor LSB/MSB, feature and the four flow-control character registers all read as, or drive, 0x00. Transmit data is 0x00, both pulses are low, and the bank is general.
- R2: With line control bit 7 = 0, the addresses decode as follows. Address 0 reads the receive data input. Address 1 reads and writes the interrupt enable register. Address 4 reads and writes the modem control register. Address 5 reads the line status input. Address 6 reads the modem status input. Address 7 reads and writes the scratchpad.
- R3: With line control bit 7 = 0, a write to address 0 latches the write data onto the transmit data output. It also raises the transmit push output for exactly the one cycle that follows the strobe.
- R4: With line control bit 7 = 0, a read of address 0 raises the receive pop output for exactly the one cycle that follows the strobe. No read at any other address, and no read in any other bank, raises it.
- R5: With line control bit 7 = 0 or in the divisor bank, a write to address 2 stores the FIFO control output. A read of address 2 returns the interrupt status input.
- R6: In the general and divisor banks, writes to addresses 5 and 6 change no register and raise no pulse.
- R7: With line control bit 7 = 1, address 0 reads and writes the divisor LSB and address 1 reads and writes the divisor MSB. Accesses to these addresses raise neither pulse.
- R8: With bit 7 = 1 and line control not equal to 0xBF, addresses 2 and 4 to 7 behave exactly as in the general bank.
- R9: With line control = 0xBF, each address maps to one register for both read and write. Address 2 is the feature register. Address 4 is flow character on-1, address 5 is on-2, address 6 is off-1 and address 7 is off-2.
- R10: Address 3 reads and writes the line control register in every bank. The new bank applies from the access that follows the write.
- R11: The bank state equals BANK_ENH exactly when line control = 0xBF. It equals BANK_DIV when bit 7 = 1 and the value is not 0xBF. Otherwise it equals BANK_GEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe |
| rx_data_i | input | 8 | Head of the receive FIFO |
| isr_i | input | 8 | Interrupt status from the interrupt logic |
| lsr_i | input | 8 | Line status |
| msr_i | input | 8 | Modem status |
| tx_data_o | output | 8 | Last transmit byte written |
| tx_push_o | output | 1 | Transmit FIFO push pulse |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| dll_o | output | 8 | Divisor LSB |
| dlm_o | output | 8 | Divisor MSB |
| efr_o | output | 8 | Feature register |
| xon1_o | output | 8 | Flow character on-1 |
| xon2_o | output | 8 | Flow character on-2 |
| xoff1_o | output | 8 | Flow character off-1 |
| xoff2_o | output | 8 | Flow character off-2 |

## Verification
The assertions rely on two assumptions about the host. Each strobe lasts one cycle, and a read and a write never arrive in the same cycle. Under these assumptions a pulse can be traced back to exactly one strobe, and the state of the line control register in the previous cycle decides what the strobe reached. The bench drives every access through tasks that raise one strobe for a single cycle and lower it before the next access, so it never breaks either assumption. The sweep covers line control values from each bank class, including the values next to 0xBF, and applies writes and reads at all eight addresses in each of them.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

    typedef enum logic [1:0] {
        BANK_GEN = 2'd0,
        BANK_DIV = 2'd1,
        BANK_ENH = 2'd2
    } bank_t;

    typedef enum logic [4:0] {
        RID_NONE,
        RID_RHR,
        RID_THR,
        RID_IER,
        RID_ISR,
        RID_FCR,
        RID_LCR,
        RID_MCR,
        RID_LSR,
        RID_MSR,
        RID_SPR,
        RID_DLL,
        RID_DLM,
        RID_EFR,
        RID_XON1,
        RID_XON2,
        RID_XOFF1,
        RID_XOFF2
    } reg_id_t;

endpackage

// File: rtl/ubr_bank_fsm.sv
module ubr_bank_fsm
    import ubr_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [DATA_W-1:0] ENH_KEY = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcr_we,
    input  logic [DATA_W-1:0] lcr_wdata,
    output bank_t             bank,
    output logic              div_visible
);

    localparam int MSB = DATA_W - 1;

    bank_t state_q;
    bank_t state_d;
    bank_t target;

    always_comb begin
        if (lcr_wdata == ENH_KEY) begin
            target = BANK_ENH;
        end else if (lcr_wdata[MSB]) begin
            target = BANK_DIV;
        end else begin
            target = BANK_GEN;
        end
    end

    // Transitions, all taken only on a line-control write:
    //   GEN -> DIV / ENH / GEN, DIV -> GEN / ENH / DIV, ENH -> GEN / DIV / ENH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_GEN: if (lcr_we) state_d = target;
            BANK_DIV: if (lcr_we) state_d = target;
            BANK_ENH: if (lcr_we) state_d = target;
            default:  state_d = BANK_GEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK_GEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bank        = state_q;
        div_visible = 1'b0;
        unique case (state_q)
            BANK_GEN: div_visible = 1'b0;
            BANK_DIV: div_visible = 1'b1;
            BANK_ENH: div_visible = 1'b1;
            default:  div_visible = 1'b0;
        endcase
    end

endmodule

// File: rtl/ubr_addr_decode.sv
module ubr_addr_decode
    import ubr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  bank_t             bank,
    input  logic [ADDR_W-1:0] addr,
    output reg_id_t           rd_sel,
    output reg_id_t           wr_sel
);

    reg_id_t gen_rd;
    reg_id_t gen_wr;

    // General bank map, also the fall-through for the divisor bank
    always_comb begin
        unique case (addr)
            3'd0: begin gen_rd = RID_RHR; gen_wr = RID_THR;  end
            3'd1: begin gen_rd = RID_IER; gen_wr = RID_IER;  end
            3'd2: begin gen_rd = RID_ISR; gen_wr = RID_FCR;  end
            3'd3: begin gen_rd = RID_LCR; gen_wr = RID_LCR;  end
            3'd4: begin gen_rd = RID_MCR; gen_wr = RID_MCR;  end
            3'd5: begin gen_rd = RID_LSR; gen_wr = RID_NONE; end
            3'd6: begin gen_rd = RID_MSR; gen_wr = RID_NONE; end
            default: begin gen_rd = RID_SPR; gen_wr = RID_SPR; end
        endcase
    end

    always_comb begin
        rd_sel = gen_rd;
        wr_sel = gen_wr;
        unique case (bank)
            BANK_GEN: begin
                rd_sel = gen_rd;
                wr_sel = gen_wr;
            end
            BANK_DIV: begin
                if (addr == 3'd0) begin
                    rd_sel = RID_DLL; wr_sel = RID_DLL;
                end else if (addr == 3'd1) begin
                    rd_sel = RID_DLM; wr_sel = RID_DLM;
                end
            end
            BANK_ENH: begin
                unique case (addr)
                    3'd0: begin rd_sel = RID_DLL;   wr_sel = RID_DLL;   end
                    3'd1: begin rd_sel = RID_DLM;   wr_sel = RID_DLM;   end
                    3'd2: begin rd_sel = RID_EFR;   wr_sel = RID_EFR;   end
                    3'd3: begin rd_sel = RID_LCR;   wr_sel = RID_LCR;   end
                    3'd4: begin rd_sel = RID_XON1;  wr_sel = RID_XON1;  end
                    3'd5: begin rd_sel = RID_XON2;  wr_sel = RID_XON2;  end
                    3'd6: begin rd_sel = RID_XOFF1; wr_sel = RID_XOFF1; end
                    default: begin rd_sel = RID_XOFF2; wr_sel = RID_XOFF2; end
                endcase
            end
            default: begin
                rd_sel = RID_NONE;
                wr_sel = RID_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ubr_regfile.sv
module ubr_regfile
    import ubr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  reg_id_t           wr_sel,
    input  reg_id_t           rd_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [DATA_W-1:0] isr_i,
    input  logic [DATA_W-1:0] lsr_i,
    input  logic [DATA_W-1:0] msr_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_push_o,
    output logic              rx_pop_o,
    output logic [DATA_W-1:0] ier_o,
    output logic [DATA_W-1:0] fcr_o,
    output logic [DATA_W-1:0] lcr_o,
    output logic [DATA_W-1:0] mcr_o,
    output logic [DATA_W-1:0] dll_o,
    output logic [DATA_W-1:0] dlm_o,
    output logic [DATA_W-1:0] efr_o,
    output logic [DATA_W-1:0] xon1_o,
    output logic [DATA_W-1:0] xon2_o,
    output logic [DATA_W-1:0] xoff1_o,
    output logic [DATA_W-1:0] xoff2_o
);

    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W-1:0] spr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_data_o <= ZERO;
            ier_o     <= ZERO;
            fcr_o     <= ZERO;
            lcr_o     <= ZERO;
            mcr_o     <= ZERO;
            spr_q     <= ZERO;
            dll_o     <= ZERO;
            dlm_o     <= ZERO;
            efr_o     <= ZERO;
            xon1_o    <= ZERO;
            xon2_o    <= ZERO;
            xoff1_o   <= ZERO;
            xoff2_o   <= ZERO;
        end else if (wr) begin
            unique case (wr_sel)
                RID_THR:   tx_data_o <= wdata;
                RID_IER:   ier_o     <= wdata;
                RID_FCR:   fcr_o     <= wdata;
                RID_LCR:   lcr_o     <= wdata;
                RID_MCR:   mcr_o     <= wdata;
                RID_SPR:   spr_q     <= wdata;
                RID_DLL:   dll_o     <= wdata;
                RID_DLM:   dlm_o     <= wdata;
                RID_EFR:   efr_o     <= wdata;
                RID_XON1:  xon1_o    <= wdata;
                RID_XON2:  xon2_o    <= wdata;
                RID_XOFF1: xoff1_o   <= wdata;
                RID_XOFF2: xoff2_o   <= wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_push_o <= 1'b0;
            rx_pop_o  <= 1'b0;
        end else begin
            tx_push_o <= wr && (wr_sel == RID_THR);
            rx_pop_o  <= rd && (rd_sel == RID_RHR);
        end
    end

    always_comb begin
        unique case (rd_sel)
            RID_RHR:   rdata = rx_data_i;
            RID_IER:   rdata = ier_o;
            RID_ISR:   rdata = isr_i;
            RID_LCR:   rdata = lcr_o;
            RID_MCR:   rdata = mcr_o;
            RID_LSR:   rdata = lsr_i;
            RID_MSR:   rdata = msr_i;
            RID_SPR:   rdata = spr_q;
            RID_DLL:   rdata = dll_o;
            RID_DLM:   rdata = dlm_o;
            RID_EFR:   rdata = efr_o;
            RID_XON1:  rdata = xon1_o;
            RID_XON2:  rdata = xon2_o;
            RID_XOFF1: rdata = xoff1_o;
            RID_XOFF2: rdata = xoff2_o;
            default:   rdata = ZERO;
        endcase
    end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import ubr_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter int                ADDR_W  = 3,
    parameter logic [DATA_W-1:0] ENH_KEY = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [DATA_W-1:0] isr_i,
    input  logic [DATA_W-1:0] lsr_i,
    input  logic [DATA_W-1:0] msr_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_push_o,
    output logic              rx_pop_o,
    output logic [DATA_W-1:0] ier_o,
    output logic [DATA_W-1:0] fcr_o,
    output logic [DATA_W-1:0] lcr_o,
    output logic [DATA_W-1:0] mcr_o,
    output logic [DATA_W-1:0] dll_o,
    output logic [DATA_W-1:0] dlm_o,
    output logic [DATA_W-1:0] efr_o,
    output logic [DATA_W-1:0] xon1_o,
    output logic [DATA_W-1:0] xon2_o,
    output logic [DATA_W-1:0] xoff1_o,
    output logic [DATA_W-1:0] xoff2_o
);

    bank_t   bank;
    logic    div_visible;
    reg_id_t rd_sel;
    reg_id_t wr_sel;
    logic    lcr_we;

    assign lcr_we = bus_wr && (wr_sel == RID_LCR);

    ubr_bank_fsm #(
        .DATA_W  (DATA_W),
        .ENH_KEY (ENH_KEY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lcr_we      (lcr_we),
        .lcr_wdata   (bus_wdata),
        .bank        (bank),
        .div_visible (div_visible)
    );

    ubr_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .bank   (bank),
        .addr   (bus_addr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    ubr_regfile #(
        .DATA_W (DATA_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .rx_data_i (rx_data_i),
        .isr_i     (isr_i),
        .lsr_i     (lsr_i),
        .msr_i     (msr_i),
        .tx_data_o (tx_data_o),
        .tx_push_o (tx_push_o),
        .rx_pop_o  (rx_pop_o),
        .ier_o     (ier_o),
        .fcr_o     (fcr_o),
        .lcr_o     (lcr_o),
        .mcr_o     (mcr_o),
        .dll_o     (dll_o),
        .dlm_o     (dlm_o),
        .efr_o     (efr_o),
        .xon1_o    (xon1_o),
        .xon2_o    (xon2_o),
        .xoff1_o   (xoff1_o),
        .xoff2_o   (xoff2_o)
    );

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk
    import ubr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic       tx_push_o,
    input logic       rx_pop_o,
    input logic [7:0] tx_data_o,
    input logic [7:0] ier_o,
    input logic [7:0] fcr_o,
    input logic [7:0] lcr_o,
    input logic [7:0] mcr_o,
    input logic [7:0] dll_o,
    input logic [7:0] dlm_o,
    input bank_t      bank
);

    AST_PUSH_FROM_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_o == $past(bus_wr && bus_addr == 3'd0 && !lcr_o[7])); // R3

    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_o |-> tx_data_o == $past(bus_wdata)); // R3

    AST_POP_FROM_RHR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o == $past(bus_rd && bus_addr == 3'd0 && !lcr_o[7])); // R4

    AST_RESERVED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd6) && lcr_o != 8'hBF)
        |=> $stable({tx_data_o, ier_o, fcr_o, lcr_o, mcr_o, dll_o, dlm_o}) && !tx_push_o); // R6

    AST_DIVISOR_LSB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && lcr_o[7]) |=> dll_o == $past(bus_wdata)); // R7

    AST_LCR_ANY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> lcr_o == $past(bus_wdata)); // R10

    AST_BANK_ENH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BANK_ENH) == (lcr_o == 8'hBF)); // R11

    AST_BANK_DIV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BANK_DIV) == (lcr_o[7] && lcr_o != 8'hBF)); // R11

endmodule

bind uart_bank_regs uart_bank_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .tx_push_o (tx_push_o),
    .rx_pop_o  (rx_pop_o),
    .tx_data_o (tx_data_o),
    .ier_o     (ier_o),
    .fcr_o     (fcr_o),
    .lcr_o     (lcr_o),
    .mcr_o     (mcr_o),
    .dll_o     (dll_o),
    .dlm_o     (dlm_o),
    .bank      (bank)
);

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] rx_data_i = 8'h11;
    logic [7:0] isr_i = 8'h22;
    logic [7:0] lsr_i = 8'h33;
    logic [7:0] msr_i = 8'h44;
    logic [7:0] tx_data_o, ier_o, fcr_o, lcr_o, mcr_o, dll_o, dlm_o;
    logic [7:0] efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
    logic       tx_push_o, rx_pop_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // bench model of every stored register
    logic [7:0] m_thr, m_ier, m_fcr, m_lcr, m_mcr, m_spr;
    logic [7:0] m_dll, m_dlm, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2;

    always #4 clk = ~clk;

    uart_bank_regs u_dut (.*);

    task automatic check8(string req, string what, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check1(string req, string what, logic got, logic exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // 0 general, 1 divisor, 2 enhanced
    function automatic int bank_of(logic [7:0] l);
        if (l == 8'hBF) return 2;
        if (l[7]) return 1;
        return 0;
    endfunction

    function automatic string req_of(int b, int a);
        if (a == 3) return "R10";
        if (b == 2) return (a < 2) ? "R7" : "R9";
        if (b == 1) begin
            if (a < 2) return "R7";
            if (a == 2) return "R5";
            if (a == 5 || a == 6) return "R6";
            return "R8";
        end
        if (a == 0) return "R3";
        if (a == 2) return "R5";
        if (a == 5 || a == 6) return "R6";
        return "R2";
    endfunction

    task automatic mdl_reset();
        {m_thr, m_ier, m_fcr, m_lcr, m_mcr, m_spr} = '0;
        {m_dll, m_dlm, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2} = '0;
    endtask

    task automatic mdl_write(int a, logic [7:0] d);
        int b = bank_of(m_lcr);
        if (b != 0 && a == 0) m_dll = d;
        else if (b != 0 && a == 1) m_dlm = d;
        else if (a == 3) m_lcr = d;
        else if (b == 2) begin
            case (a)
                2: m_efr = d;
                4: m_xon1 = d;
                5: m_xon2 = d;
                6: m_xoff1 = d;
                default: m_xoff2 = d;
            endcase
        end else begin
            case (a)
                0: m_thr = d;
                1: m_ier = d;
                2: m_fcr = d;
                4: m_mcr = d;
                7: m_spr = d;
                default: ;
            endcase
        end
    endtask

    function automatic logic [7:0] mdl_read(int a);
        int b = bank_of(m_lcr);
        if (b != 0 && a == 0) return m_dll;
        if (b != 0 && a == 1) return m_dlm;
        if (a == 3) return m_lcr;
        if (b == 2) begin
            case (a)
                2: return m_efr;
                4: return m_xon1;
                5: return m_xon2;
                6: return m_xoff1;
                default: return m_xoff2;
            endcase
        end
        case (a)
            0: return rx_data_i;
            1: return m_ier;
            2: return isr_i;
            4: return m_mcr;
            5: return lsr_i;
            6: return msr_i;
            default: return m_spr;
        endcase
    endfunction

    task automatic check_outputs(string req);
        check8(req, "tx_data", tx_data_o, m_thr);
        check8(req, "ier", ier_o, m_ier);
        check8(req, "fcr", fcr_o, m_fcr);
        check8(req, "lcr", lcr_o, m_lcr);
        check8(req, "mcr", mcr_o, m_mcr);
        check8(req, "dll", dll_o, m_dll);
        check8(req, "dlm", dlm_o, m_dlm);
        check8(req, "efr", efr_o, m_efr);
        check8(req, "xon1", xon1_o, m_xon1);
        check8(req, "xon2", xon2_o, m_xon2);
        check8(req, "xoff1", xoff1_o, m_xoff1);
        check8(req, "xoff2", xoff2_o, m_xoff2);
    endtask

    task automatic bus_write(int a, logic [7:0] d);
        string req = req_of(bank_of(m_lcr), a);
        logic  exp_push = (bank_of(m_lcr) == 0) && (a == 0);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        mdl_write(a, d);
        check1(exp_push ? "R3" : req, "tx_push", tx_push_o, exp_push);
        check1(req, "rx_pop on write", rx_pop_o, 1'b0);
        check_outputs(req);
        @(negedge clk);
        check1("R3", "tx_push drop", tx_push_o, 1'b0);
    endtask

    task automatic bus_read(int a);
        int    b = bank_of(m_lcr);
        string req = req_of(b, a);
        logic  exp_pop = (b == 0) && (a == 0);
        @(negedge clk);
        bus_addr = 3'(a);
        bus_rd   = 1'b1;
        #1;
        check8(req, $sformatf("read addr %0d", a), bus_rdata, mdl_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
        check1(exp_pop ? "R4" : "R4 no-pop", "rx_pop", rx_pop_o, exp_pop);
        @(negedge clk);
        check1("R4", "rx_pop drop", rx_pop_o, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lcr_set [8] = '{8'h00, 8'h03, 8'h80, 8'h83, 8'hBF, 8'hBE, 8'hFF, 8'h3F};
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1");
        check1("R1", "tx_push", tx_push_o, 1'b0);
        check1("R1", "rx_pop", rx_pop_o, 1'b0);
        for (int a = 0; a < 8; a++) bus_read(a);

        for (int pass = 0; pass < 3; pass++) begin
            for (int k = 0; k < 8; k++) begin
                rx_data_i = 8'(8'h10 + 17 * k + pass);
                isr_i     = 8'(8'hC1 ^ (k * 5 + pass));
                lsr_i     = 8'(8'h60 + k * 3 + pass);
                msr_i     = 8'(8'h9A - k - pass * 7);
                bus_write(3, lcr_set[k]);          // R10 bank change
                for (int a = 0; a < 8; a++) begin
                    if (a != 3) bus_write(a, 8'((k * 37) + (a * 11) + (pass * 91) + 1));
                end
                for (int a = 0; a < 8; a++) bus_read(a);
            end
        end

        // R10: leaving the enhanced bank straight back to general
        bus_write(3, 8'hBF);
        bus_write(3, 8'h01);
        for (int a = 0; a < 8; a++) bus_read(a);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule